// File: doc/BRIEF.md
# Neural-Network Helper Execution Unit

This unit executes three arithmetic helpers for small neural-network kernels on a 32-bit core. It decodes one instruction word and takes three operand values: two source operands and the current content of the destination register, which acts as an accumulator input. It then produces one of three results:

- a signed saturation that is preceded by an arithmetic right shift;
- a four-lane signed byte dot product that is added to the accumulator;
- a signed 32-bit multiply-accumulate.

The outcome comes out on a registered result port together with a write enable, the destination index and an illegal-instruction flag. The result appears one cycle after the request.

The surrounding pipeline fetches the operands from the register file and applies the write. The unit has a two-state output sequencer. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is presented this cycle. A cycle with `in_valid` high moves the sequencer to `ST_RESULT` (transition "issue"). A cycle with `in_valid` low moves it to `ST_IDLE` (transition "drain"). Back-to-back requests keep it in `ST_RESULT`.

Top module: `nn_helper_unit`

## Requirements
- R1: After reset, `out_valid`, `out_we` and `out_illegal` are all 0.
- R2: A request with `in_valid` high produces `out_valid` = 1 exactly one clock later, with `out_rd` = `instr[11:7]`. A cycle without a request produces `out_valid` = 0 and `out_we` = 0 one clock later.
- R3: The unit recognises the major opcode `instr[6:0]` = 7'b0101011. The operation is selected by `instr[14:12]`: 3'b000 is saturate, 3'b001 is dot product and 3'b010 is multiply-accumulate. `instr[31:25]` is the secondary field.
- R4: Saturate shifts `src_a` arithmetically right by `src_b`. It then clamps the shifted value to the range from -2^(n-1) to 2^(n-1)-1, where n = `instr[31:25]`.
- R5: Saturate writes only if all of these hold: rd ≠ 0, 1 ≤ n ≤ 32, and `src_b` (unsigned) < 32. Otherwise `out_we` = 0 and `out_illegal` = 0.
- R6: Saturate with n = 32 returns the shifted value unchanged.
- R7: The dot product treats bytes [7:0], [15:8], [23:16] and [31:24] of `src_a` and `src_b` as signed lanes. It multiplies matching lanes, sums the four products, adds `acc_in`, and outputs the low 32 bits.
- R8: Multiply-accumulate outputs the low 32 bits of signed `src_a`×`src_b` plus `acc_in`.
- R9: Any operation with rd = 0 gives `out_we` = 0, and the flag is not illegal on that account.
- R10: `out_illegal` = 1 and `out_we` = 0 when any of these holds: the opcode differs from the one in R3, `instr[14:12]` > 3'b010, or `instr[31:25]` ≠ 0 on a dot product or multiply-accumulate.
- R11: Whenever `out_valid` = 1 and `out_we` = 0, `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand (shift amount for saturate) |
| acc_in | input | 32 | Prior destination value used as accumulator |
| out_valid | output | 1 | Result presented this cycle |
| out_we | output | 1 | Destination write enable |
| out_rd | output | 5 | Destination register index |
| out_data | output | 32 | Result value, zero when no write |
| out_illegal | output | 1 | Instruction not accepted by this unit |

## Verification
A wrong sequencer state shows at once as `out_valid` or `out_we` set or missing in the cycle after a request or an idle cycle. A wrong decode or write condition shows in that same cycle as a flipped `out_we` or `out_illegal`, or as a nonzero `out_data` on a suppressed write. Arithmetic faults, such as a wrong lane sign, a wrong clamp bound or a logical instead of arithmetic shift, only show when a request hits the affected operand pattern. For that reason the bench sweeps every saturation position from 0 to 34 across boundary shifts and operands, and drives the lane-extreme products explicitly.

// File: rtl/nnu_pkg.sv
`timescale 1ns/1ps
package nnu_pkg;
    localparam logic [6:0] NNU_MAJOR_OP = 7'b0101011;

    typedef enum logic [1:0] {
        OP_SAT = 2'd0,
        OP_DOT = 2'd1,
        OP_MAC = 2'd2,
        OP_BAD = 2'd3
    } nnu_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } nnu_state_e;

    typedef struct packed {
        nnu_op_e    op;
        logic [6:0] sub;
        logic [4:0] rd;
    } nnu_dec_t;
endpackage

// File: rtl/nnu_decode.sv
`timescale 1ns/1ps
module nnu_decode
    import nnu_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr,
    output nnu_dec_t        dec,
    output logic            illegal
);
    logic [2:0] sel;
    assign sel = instr[14:12];

    always_comb begin
        dec.rd  = instr[11:7];
        dec.sub = instr[31:25];
        dec.op  = OP_BAD;
        illegal = 1'b0;
        if (instr[6:0] != NNU_MAJOR_OP) begin
            illegal = 1'b1;
        end else begin
            unique case (sel)
                3'b000: dec.op = OP_SAT;
                3'b001: begin
                    dec.op  = OP_DOT;
                    illegal = (instr[31:25] != 7'd0);
                end
                3'b010: begin
                    dec.op  = OP_MAC;
                    illegal = (instr[31:25] != 7'd0);
                end
                default: illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/nnu_sat.sv
`timescale 1ns/1ps
module nnu_sat #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] value,
    input  logic [XLEN-1:0] shamt,
    input  logic [6:0]      pos,
    output logic [XLEN-1:0] res,
    output logic            ok
);
    localparam int              SHW     = $clog2(XLEN);
    localparam logic [6:0]      POS_MAX = 7'(XLEN);
    localparam logic [XLEN-1:0] SH_LIM  = XLEN'(XLEN);

    logic signed [XLEN-1:0] shifted;
    logic signed [XLEN:0]   wide, lim, hi, lo;
    logic [6:0]             pos_m1;

    always_comb begin
        ok      = (pos != 7'd0) && (pos <= POS_MAX) && (shamt < SH_LIM);
        shifted = $signed(value) >>> shamt[SHW-1:0];
        wide    = {shifted[XLEN-1], shifted};
        pos_m1  = pos - 7'd1;
        lim     = {{XLEN{1'b0}}, 1'b1} << pos_m1;
        hi      = lim - 1;
        lo      = -lim;
        if (wide > hi)      res = hi[XLEN-1:0];
        else if (wide < lo) res = lo[XLEN-1:0];
        else                res = shifted;
    end

    // R6
    always_comb begin
        if (ok && pos == POS_MAX) begin
            full_range_pass_chk: assert (res == shifted);
        end
    end
endmodule

// File: rtl/nnu_dot.sv
`timescale 1ns/1ps
module nnu_dot #(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] acc,
    output logic [XLEN-1:0] res
);
    localparam int LANES = XLEN / LANE_W;
    localparam int PW    = 2 * LANE_W;
    localparam int SW    = PW + $clog2(LANES) + 1;

    logic signed [PW-1:0] prod [LANES];
    logic signed [SW-1:0] sum;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign prod[g] = $signed(a[g*LANE_W +: LANE_W]) * $signed(b[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + SW'(prod[i]);
        end
        res = acc + XLEN'(sum);
    end
endmodule

// File: rtl/nnu_mac.sv
`timescale 1ns/1ps
module nnu_mac #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] acc,
    output logic [XLEN-1:0] res
);
    logic signed [2*XLEN-1:0] prod;

    always_comb begin
        prod = $signed(a) * $signed(b);
        res  = prod[XLEN-1:0] + acc;
    end
endmodule

// File: rtl/nn_helper_unit.sv
`timescale 1ns/1ps
module nn_helper_unit
    import nnu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] acc_in,
    output logic            out_valid,
    output logic            out_we,
    output logic [4:0]      out_rd,
    output logic [XLEN-1:0] out_data,
    output logic            out_illegal
);
    nnu_dec_t        dec;
    logic            dec_illegal;
    logic [XLEN-1:0] sat_res, dot_res, mac_res;
    logic            sat_ok;
    logic            nxt_we;
    logic [XLEN-1:0] nxt_data;
    nnu_state_e      state;

    nnu_decode #(.ILEN(32)) u_decode (
        .instr   (instr),
        .dec     (dec),
        .illegal (dec_illegal)
    );

    nnu_sat #(.XLEN(XLEN)) u_sat (
        .value (src_a),
        .shamt (src_b),
        .pos   (dec.sub),
        .res   (sat_res),
        .ok    (sat_ok)
    );

    nnu_dot #(.XLEN(XLEN), .LANE_W(LANE_W)) u_dot (
        .a   (src_a),
        .b   (src_b),
        .acc (acc_in),
        .res (dot_res)
    );

    nnu_mac #(.XLEN(XLEN)) u_mac (
        .a   (src_a),
        .b   (src_b),
        .acc (acc_in),
        .res (mac_res)
    );

    always_comb begin
        nxt_we   = 1'b0;
        nxt_data = '0;
        if (!dec_illegal && dec.rd != 5'd0) begin
            unique case (dec.op)
                OP_SAT: begin
                    nxt_we   = sat_ok;
                    nxt_data = sat_ok ? sat_res : '0;
                end
                OP_DOT: begin
                    nxt_we   = 1'b1;
                    nxt_data = dot_res;
                end
                OP_MAC: begin
                    nxt_we   = 1'b1;
                    nxt_data = mac_res;
                end
                default: begin
                    nxt_we   = 1'b0;
                    nxt_data = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= in_valid ? ST_RESULT : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_we      <= 1'b0;
            out_rd      <= 5'd0;
            out_data    <= '0;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            out_we      <= nxt_we;
            out_rd      <= dec.rd;
            out_data    <= nxt_data;
            out_illegal <= dec_illegal;
        end else begin
            out_we      <= 1'b0;
            out_illegal <= 1'b0;
            out_data    <= '0;
        end
    end

    assign out_valid = (state == ST_RESULT);

    // R2
    issue_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_rd == $past(instr[11:7])));

    // R2
    drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_we));

    // R9
    no_write_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_rd != 5'd0));

    // R10
    illegal_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_we);

    // R11
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_we) |-> (out_data == '0));
endmodule

// File: tb/nn_helper_unit_bench.sv
`timescale 1ns/1ps
module nn_helper_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, src_a = '0, src_b = '0, acc_in = '0;
    logic        out_valid, out_we, out_illegal;
    logic [4:0]  out_rd;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nn_helper_unit u_nn_helper_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .out_we(out_we), .out_rd(out_rd),
        .out_data(out_data), .out_illegal(out_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] op);
        return {f7, 5'd3, 5'd2, f3, rd, op};
    endfunction

    function automatic logic [31:0] dot_model(input logic [31:0] a, b, acc);
        int s = 0;
        for (int i = 0; i < 4; i++) begin
            s += int'($signed(a[8*i +: 8])) * int'($signed(b[8*i +: 8]));
        end
        return acc + 32'(s);
    endfunction

    function automatic logic [31:0] mac_model(input logic [31:0] a, b, acc);
        longint p = longint'($signed(a)) * longint'($signed(b));
        return p[31:0] + acc;
    endfunction

    task automatic issue(input logic [31:0] ins, a, b, acc, input string req);
        logic [6:0]  f7 = ins[31:25];
        logic [2:0]  f3 = ins[14:12];
        logic [4:0]  rd = ins[11:7];
        logic        ill, we, sok;
        logic [31:0] val;
        longint      v, hi, lo;
        ill = (ins[6:0] != 7'b0101011) || (f3 > 3'd2) || (f3 != 3'd0 && f7 != 7'd0);
        sok = (f7 >= 7'd1) && (f7 <= 7'd32) && (b < 32);
        v   = longint'($signed(a)) >>> b[4:0];
        hi  = (64'sd1 <<< (int'(f7) - 1)) - 1;
        lo  = -(64'sd1 <<< (int'(f7) - 1));
        if (v > hi) v = hi;
        else if (v < lo) v = lo;
        case (f3)
            3'd0:    begin we = sok; val = v[31:0]; end
            3'd1:    begin we = 1'b1; val = dot_model(a, b, acc); end
            default: begin we = 1'b1; val = mac_model(a, b, acc); end
        endcase
        we = we && !ill && (rd != 5'd0);
        if (!we) val = '0;
        @(negedge clk);
        in_valid = 1'b1; instr = ins; src_a = a; src_b = b; acc_in = acc;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, 32'(out_valid), 32'd1);
        chk({req, " R2 rd"}, 32'(out_rd), 32'(rd));
        chk({req, " R10 illegal"}, 32'(out_illegal), 32'(ill));
        chk({req, " we"}, 32'(out_we), 32'(we));
        chk({req, we ? " data" : " R11 data"}, out_data, val);
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] avals [5] = '{32'h7fffffff, 32'h80000000, 32'h12345678, 32'hfffffff0, 32'h0};
        logic [31:0] svals [6] = '{32'd0, 32'd1, 32'd5, 32'd31, 32'd32, 32'd1000};
        repeat (3) @(negedge clk);
        // R1
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 out_we", 32'(out_we), 32'd0);
        chk("R1 out_illegal", 32'(out_illegal), 32'd0);
        rst_n = 1'b1;

        // R3 R4 R5 R6 saturate sweep
        for (int n = 0; n <= 34; n++) begin
            for (int s = 0; s < 6; s++) begin
                for (int k = 0; k < 5; k++) begin
                    issue(mk(7'(n), 3'd0, 5'd5, 7'b0101011), avals[k], svals[s], 32'hdead,
                          (n == 32) ? "R6 sat" : ((n >= 1 && n <= 32 && s < 4) ? "R4 sat" : "R5 sat"));
                end
            end
        end
        issue(mk(7'd127, 3'd0, 5'd6, 7'b0101011), 32'h1, 32'd0, 32'h0, "R5 sat n127");
        issue(mk(7'd8, 3'd0, 5'd0, 7'b0101011), 32'h7fff, 32'd0, 32'h0, "R9 sat rd0");

        // R3 R7 dot product: lane extremes then random
        issue(mk(7'd0, 3'd1, 5'd7, 7'b0101011), 32'h80808080, 32'h80808080, 32'h0, "R7 dot min");
        issue(mk(7'd0, 3'd1, 5'd7, 7'b0101011), 32'h7f7f7f7f, 32'h80808080, 32'h5, "R7 dot mix");
        issue(mk(7'd0, 3'd1, 5'd7, 7'b0101011), 32'h017f80ff, 32'hff01807f, 32'hffffffff, "R7 dot lanes");
        for (int i = 0; i < 200; i++) begin
            issue(mk(7'd0, 3'd1, 5'(1 + i % 31), 7'b0101011), $urandom, $urandom, $urandom, "R7 dot");
        end
        issue(mk(7'd0, 3'd1, 5'd0, 7'b0101011), 32'h01010101, 32'h01010101, 32'h0, "R9 dot rd0");

        // R3 R8 multiply-accumulate
        issue(mk(7'd0, 3'd2, 5'd9, 7'b0101011), 32'h80000000, 32'hffffffff, 32'h1, "R8 mac edge");
        issue(mk(7'd0, 3'd2, 5'd9, 7'b0101011), 32'hfffffffd, 32'h00000007, 32'h100, "R8 mac neg");
        for (int i = 0; i < 200; i++) begin
            issue(mk(7'd0, 3'd2, 5'(1 + i % 31), 7'b0101011), $urandom, $urandom, $urandom, "R8 mac");
        end
        issue(mk(7'd0, 3'd2, 5'd0, 7'b0101011), 32'h3, 32'h4, 32'h0, "R9 mac rd0");

        // R10 illegal encodings
        for (int f = 3; f < 8; f++) begin
            issue(mk(7'd0, 3'(f), 5'd4, 7'b0101011), 32'h5, 32'h6, 32'h7, "R10 funct3");
        end
        for (int f = 1; f < 128; f += 21) begin
            issue(mk(7'(f), 3'd1, 5'd4, 7'b0101011), 32'h5, 32'h6, 32'h7, "R10 dot sub");
            issue(mk(7'(f), 3'd2, 5'd4, 7'b0101011), 32'h5, 32'h6, 32'h7, "R10 mac sub");
        end
        issue(mk(7'd0, 3'd2, 5'd4, 7'b0001011), 32'h5, 32'h6, 32'h7, "R10 opcode");

        // R2 drain: one idle cycle after last result
        @(negedge clk);
        chk("R2 idle valid", 32'(out_valid), 32'd0);
        chk("R2 idle we", 32'(out_we), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule